// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block is a small synchronous finite-state machine that inspects one serial bit per clock and flags every place where the four most recent bits, oldest first, read 1, 1, 0, 1. Occurrences may share bits. In the stream 1101101, the final 1 of the first hit is also the first bit of the second hit, so both are reported.

The detect output is a Mealy output. It is formed from the present state and the bit that is on the input in the same cycle. It therefore rises during the cycle in which the closing 1 is presented, with no added register delay. A consumer that needs a registered flag can sample it on the next edge.

The progress through the pattern is held in a two-bit state register. The four codes are all in use, and the sequence of codes moves one bit at a time: idle = 00, seen "1" = 01, seen "11" = 11, seen "110" = 10. Reset is synchronous and active-high. It returns the register to the idle code.

Top module: `seqdet_1101`

## Requirements
- R1: While `rst` is high, `detect` is 0 whatever the state and the value of `din`.
- R2: `detect` is 1 in the same cycle that `din` is 1, when the three bits sampled on the preceding rising edges were 1, 1, 0, oldest first.
- R3: Matches overlap. The closing 1 of a match counts as the first bit of the next match, so 1101101 gives a detection on bits 4 and 7.
- R4: `detect` is 0 in every cycle in which `din` is 0.
- R5: A run of any number of 1s followed by 0 then 1 is detected. Extra leading 1s do not discard the progress.
- R6: After 1, 1, 0, a further 0 discards all progress. A complete 1101 is then needed before the next detection.
- R7: A reset pulse in the middle of a partial match discards it. The machine restarts from the idle state (code 00) on the first edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the idle state |
| din | input | 1 | Serial data bit, sampled on each rising edge |
| detect | output | 1 | Mealy detect flag, high while the closing 1 of 1101 is presented |

## Verification
On every cycle the assertions check the following:
- `detect` stays low under reset and whenever `din` is 0.
- The register takes the expected code after each transition that shapes overlap and recovery: a hit goes to 01, a run of 1s holds at 11, and a 0 after 110 goes to 00.
- A reset edge lands on 00.

Only the bench scenarios can show the stream-level behaviour. These cover that hits appear on exactly the right bit positions in long streams, that overlapping matches both fire, and that a reset in the middle of a match costs the full four bits afterwards.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    S_NONE = 2'b00,
    S_1    = 2'b01,
    S_11   = 2'b11,
    S_110  = 2'b10
  } seq_state_t;
endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  seq_state_t cur,
  input  logic       bit_in,
  output seq_state_t nxt
);
  always_comb begin
    nxt = S_NONE;
    unique case (cur)
      S_NONE: nxt = bit_in ? S_1   : S_NONE;
      S_1:    nxt = bit_in ? S_11  : S_NONE;
      S_11:   nxt = bit_in ? S_11  : S_110;
      S_110:  nxt = bit_in ? S_1   : S_NONE;
      default: nxt = S_NONE;
    endcase
  end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t nxt,
  output seq_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= S_NONE;
    else     cur <= nxt;
  end

  // R7: a reset edge always lands on the idle code
  property p_reset_idle;
    @(posedge clk) rst |=> (cur == S_NONE);
  endproperty
  assert_reset_idle_R7: assert property (p_reset_idle);
endmodule

// File: rtl/seqdet_out.sv
module seqdet_out
  import seqdet_pkg::*;
(
  input  logic       rst,
  input  seq_state_t cur,
  input  logic       bit_in,
  output logic       hit
);
  always_comb hit = !rst && (cur == S_110) && bit_in;

  always_comb begin
    if (rst) assert_quiet_in_reset_R1: assert (!hit);
    if (hit) assert_hit_needs_one_R4: assert (bit_in);
  end
endmodule

// File: rtl/seqdet_1101.sv
module seqdet_1101
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic detect
);
  seq_state_t state_q;
  seq_state_t state_d;

  seqdet_next u_next (
    .cur    (state_q),
    .bit_in (din),
    .nxt    (state_d)
  );

  seqdet_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (state_d),
    .cur (state_q)
  );

  seqdet_out u_out (
    .rst    (rst),
    .cur    (state_q),
    .bit_in (din),
    .hit    (detect)
  );

  // R3: a hit hands its closing 1 on as the first bit of the next match
  property p_overlap;
    @(posedge clk) disable iff (rst)
      detect |=> (state_q == S_1);
  endproperty
  assert_overlap_R3: assert property (p_overlap);

  // R5: extra 1s keep the "11" progress
  property p_hold_ones;
    @(posedge clk) disable iff (rst)
      (state_q == S_11 && din) |=> (state_q == S_11);
  endproperty
  assert_hold_ones_R5: assert property (p_hold_ones);

  // R6: 1100 discards progress
  property p_drop_on_zero;
    @(posedge clk) disable iff (rst)
      (state_q == S_110 && !din) |=> (state_q == S_NONE);
  endproperty
  assert_drop_on_zero_R6: assert property (p_drop_on_zero);
endmodule

// File: tb/seqdet_1101_tb.sv
module seqdet_1101_tb;
  localparam int N_VEC = 23;
  // each entry {din, expected detect}
  localparam logic [1:0] VEC [0:N_VEC-1] = '{
    2'b10, 2'b10, 2'b00, 2'b11,
    2'b10, 2'b00, 2'b11,
    2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 2'b11,
    2'b10, 2'b00, 2'b00,
    2'b10, 2'b00, 2'b10, 2'b10, 2'b00, 2'b11
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic detect;
  int   n_checks = 0;
  int   n_fail = 0;

  always #2.5 clk = ~clk;

  seqdet_1101 u_dut (.clk(clk), .rst(rst), .din(din), .detect(detect));

  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: detect=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // drive at the falling edge, sample the Mealy output 1 ns later
  task automatic step(input logic r, input logic b, input string tag, input logic exp);
    @(negedge clk);
    rst = r;
    din = b;
    #1;
    check(tag, detect, exp);
  endtask

  initial begin
    #1000000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state, output low under reset with either input
    step(1'b1, 1'b0, "R1", 1'b0);
    step(1'b1, 1'b1, "R1", 1'b0);

    for (int i = 0; i < N_VEC; i++) begin
      string tag;
      if (i == 6)              tag = "R3";
      else if (i == 13)        tag = "R5";
      else if (i == 16)        tag = "R6";
      else if (VEC[i][1] == 0) tag = "R4";
      else                     tag = "R2";
      step(1'b0, VEC[i][1], tag, VEC[i][0]);
    end

    // R1: reset while the machine waits for the closing 1
    step(1'b0, 1'b1, "R2", 1'b0);
    step(1'b0, 1'b0, "R4", 1'b0);
    step(1'b1, 1'b1, "R1", 1'b0);
    // R7: partial match was discarded, a full 1101 is needed again
    step(1'b0, 1'b1, "R7", 1'b0);
    step(1'b0, 1'b1, "R7", 1'b0);
    step(1'b0, 1'b0, "R7", 1'b0);
    step(1'b0, 1'b1, "R7", 1'b1);
    // R3: back-to-back overlap once more: 101 after a hit
    step(1'b0, 1'b1, "R3", 1'b0);
    step(1'b0, 1'b0, "R3", 1'b0);
    step(1'b0, 1'b1, "R3", 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule